// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block runs the multi-cycle control sequences of an 8-bit processor that touch the hardware stack or the vector area. It covers the power-up vector load, hardware interrupt entry, software break, subroutine call and return, and return from interrupt. Opcode decode, the ALU and address generation sit outside the block. The instruction sequencer starts a sequence by driving a one-hot command for one cycle. With that command it supplies the current program counter, the status byte and, for a call, the target address. The block then drives a single-port synchronous memory, one access per cycle. When it finishes it pulses `done_o`, and the new program counter, status byte and stack pointer are valid on its outputs from that cycle on.

Non-maskable and maskable requests arrive as pulses and are held in pending latches. They are only looked at when the instruction sequencer issues the poll command. The poll comes one cycle before the current instruction completes. The poll resolves to one of three outcomes: an NMI entry, an IRQ entry, or an empty sequence that finishes with the incoming values passed through unchanged.

Top module: `isq_sequencer`

## Requirements
- R1: After `rst_ni` is released, `sp_o` is 0xFD and `status_o` is 0x34. The reset command (`cmd_i` bit 0) also sets SP to 0xFD and status to 0x34. It then reads 0xFFFC and 0xFFFD and sets `pc_o` = {byte at 0xFFFD, byte at 0xFFFC}.
- R2: The stack lives in page 0x01. A push writes address {0x01, SP} and then decrements SP. A pull first increments SP and then reads {0x01, SP}. SP wraps modulo 256 and never leaves the page. No write ever targets another page.
- R3: On a poll (`cmd_i` bit 1), a pending NMI is always taken, whatever status bit 2 holds. It takes precedence over a pending IRQ.
- R4: A pending IRQ is taken at a poll only if status bit 2 (interrupt disable) is 0 and no NMI is pending. Otherwise the poll performs no memory write, and it leaves `pc_o`=`pc_i`, `status_o`=`status_i` and SP unchanged.
- R5: Hardware entry pushes PC[15:8], then PC[7:0], then the status with bit 4 cleared and bit 5 kept as given. NMI then loads the PC from 0xFFFA/0xFFFB and leaves status unchanged. IRQ sets status bit 2 and loads the PC from 0xFFFE/0xFFFF.
- R6: `nmi_i` and `irq_i` pulses are latched until a poll services them. Servicing clears only that latch. A pulse that arrives during a running sequence, or in the very cycle its latch is cleared, stays pending for the next poll.
- R7: Break (`cmd_i` bit 2) pushes PC+1 (high byte first) and then status with bits 5 and 4 set. It sets status bit 2 and loads the PC from 0xFFFE/0xFFFF.
- R8: Call (`cmd_i` bit 3) pushes PC-1 (high byte first) and then sets `pc_o` to `target_i`.
- R9: Return (`cmd_i` bit 4) pulls the low byte and then the high byte, and sets `pc_o` to that value plus 1.
- R10: Return from interrupt (`cmd_i` bit 5) pulls the status and forces bits 5 and 4 to 1. It then pulls PC low and PC high and adds nothing.
- R11: A sequence with k memory accesses raises `done_o` for exactly one cycle, k+2 cycles after the edge that accepted the command. `busy_o` is high from the accept edge until the cycle before `done_o`.
- R12: A command is accepted only when `busy_o` is low and exactly one `cmd_i` bit is set. Any other command value is ignored, with no memory access and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 6 | One-hot command: 0 reset, 1 poll, 2 break, 3 call, 4 return, 5 return from interrupt |
| nmi_i | input | 1 | Non-maskable request pulse |
| irq_i | input | 1 | Maskable request pulse |
| pc_i | input | 16 | Current program counter, sampled at accept |
| status_i | input | 8 | Current status byte, sampled at accept |
| target_i | input | 16 | Call target, sampled at accept |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the address |
| pc_o | output | 16 | Resulting program counter |
| status_o | output | 8 | Resulting status byte |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Latching a new request and clearing the same latch can fall in one cycle. The clear happens when a poll that services an NMI is accepted. The bench provokes this by pulsing `nmi_i` in exactly that accept cycle while an IRQ is also pending. It then judges the result by what the next two polls do. The second poll must enter NMI again and not IRQ, and only the third poll may take the IRQ. A pulse that lands inside a running call must likewise survive to the next poll.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int DW     = 8;
  localparam int AW     = 16;
  localparam int CMD_W  = 6;
  localparam int STEP_W = 3;
  localparam int N_REQ  = 2;

  localparam int CMD_RESET = 0;
  localparam int CMD_POLL  = 1;
  localparam int CMD_BRK   = 2;
  localparam int CMD_CALL  = 3;
  localparam int CMD_RET   = 4;
  localparam int CMD_RTI   = 5;

  localparam int REQ_NMI = 0;
  localparam int REQ_IRQ = 1;

  localparam int ST_I = 2;
  localparam int ST_B = 4;
  localparam int ST_U = 5;
  localparam logic [DW-1:0] I_MASK  = DW'(1) << ST_I;
  localparam logic [DW-1:0] B_MASK  = DW'(1) << ST_B;
  localparam logic [DW-1:0] BU_MASK = (DW'(1) << ST_B) | (DW'(1) << ST_U);

  typedef enum logic [2:0] {
    SEQ_NONE, SEQ_RESET, SEQ_NMI, SEQ_IRQ, SEQ_BRK, SEQ_CALL, SEQ_RET, SEQ_RTI
  } seq_e;

  typedef enum logic [3:0] {
    UOP_END, UOP_PUSH_PCH, UOP_PUSH_PCL, UOP_PUSH_ST,
    UOP_PULL_PCL, UOP_PULL_PCH, UOP_PULL_ST, UOP_VEC_LO, UOP_VEC_HI
  } uop_e;

  typedef enum logic [1:0] {CAP_NONE, CAP_PCL, CAP_PCH, CAP_ST} cap_e;
endpackage

// File: rtl/isq_req_latch.sv
module isq_req_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= (pend_q & ~clr_i[g]) | set_i[g];
    end
    assign pend_o[g] = pend_q;

    // R6
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]);
    // R6
    clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
  end
endmodule

// File: rtl/isq_uop_rom.sv
module isq_uop_rom
  import isq_pkg::*;
(
  input  seq_e              kind_i,
  input  logic [STEP_W-1:0] step_i,
  output uop_e              uop_o
);
  always_comb begin
    uop_o = UOP_END;
    case (kind_i)
      SEQ_RESET: case (step_i)
        3'd0:    uop_o = UOP_VEC_LO;
        3'd1:    uop_o = UOP_VEC_HI;
        default: uop_o = UOP_END;
      endcase
      SEQ_NMI, SEQ_IRQ, SEQ_BRK: case (step_i)
        3'd0:    uop_o = UOP_PUSH_PCH;
        3'd1:    uop_o = UOP_PUSH_PCL;
        3'd2:    uop_o = UOP_PUSH_ST;
        3'd3:    uop_o = UOP_VEC_LO;
        3'd4:    uop_o = UOP_VEC_HI;
        default: uop_o = UOP_END;
      endcase
      SEQ_CALL: case (step_i)
        3'd0:    uop_o = UOP_PUSH_PCH;
        3'd1:    uop_o = UOP_PUSH_PCL;
        default: uop_o = UOP_END;
      endcase
      SEQ_RET: case (step_i)
        3'd0:    uop_o = UOP_PULL_PCL;
        3'd1:    uop_o = UOP_PULL_PCH;
        default: uop_o = UOP_END;
      endcase
      SEQ_RTI: case (step_i)
        3'd0:    uop_o = UOP_PULL_ST;
        3'd1:    uop_o = UOP_PULL_PCL;
        3'd2:    uop_o = UOP_PULL_PCH;
        default: uop_o = UOP_END;
      endcase
      default: uop_o = UOP_END;
    endcase
  end
endmodule

// File: rtl/isq_datapath.sv
module isq_datapath
  import isq_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] RST_SP     = 8'hFD,
  parameter logic [DW-1:0] RST_STATUS = 8'h34,
  parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  seq_e          load_kind_i,
  input  logic          active_i,
  input  seq_e          kind_i,
  input  uop_e          uop_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] status_i,
  input  logic [AW-1:0] target_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] sp_o
);
  logic [AW-1:0] pc_q, pc_cap, tgt_q, vec_base;
  logic [DW-1:0] st_q, st_cap, sp_q, sp_inc;
  cap_e          cap_q, cap_d;

  assign sp_inc = sp_q + 8'd1;

  always_comb begin
    case (kind_i)
      SEQ_RESET: vec_base = VEC_RST;
      SEQ_NMI:   vec_base = VEC_NMI;
      default:   vec_base = VEC_IRQ;
    endcase
  end

  // merge the byte read in the previous cycle
  always_comb begin
    pc_cap = pc_q;
    st_cap = st_q;
    case (cap_q)
      CAP_PCL: pc_cap[7:0]  = mem_rdata_i;
      CAP_PCH: pc_cap[15:8] = mem_rdata_i;
      CAP_ST:  st_cap       = mem_rdata_i | BU_MASK;
      default: ;
    endcase
  end

  always_comb begin
    mem_addr_o  = {STACK_PAGE, sp_q};
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    cap_d       = CAP_NONE;
    if (active_i) begin
      case (uop_i)
        UOP_PUSH_PCH: begin mem_we_o = 1'b1; mem_wdata_o = pc_q[15:8]; end
        UOP_PUSH_PCL: begin mem_we_o = 1'b1; mem_wdata_o = pc_q[7:0];  end
        UOP_PUSH_ST: begin
          mem_we_o    = 1'b1;
          mem_wdata_o = (kind_i == SEQ_BRK) ? (st_q | BU_MASK) : (st_q & ~B_MASK);
        end
        UOP_PULL_ST:  begin mem_addr_o = {STACK_PAGE, sp_inc}; cap_d = CAP_ST;  end
        UOP_PULL_PCL: begin mem_addr_o = {STACK_PAGE, sp_inc}; cap_d = CAP_PCL; end
        UOP_PULL_PCH: begin mem_addr_o = {STACK_PAGE, sp_inc}; cap_d = CAP_PCH; end
        UOP_VEC_LO:   begin mem_addr_o = vec_base;             cap_d = CAP_PCL; end
        UOP_VEC_HI:   begin mem_addr_o = vec_base + 16'd1;     cap_d = CAP_PCH; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      tgt_q <= '0;
      st_q  <= RST_STATUS;
      sp_q  <= RST_SP;
      cap_q <= CAP_NONE;
    end else begin
      cap_q <= cap_d;
      if (load_i) begin
        tgt_q <= target_i;
        case (load_kind_i)
          SEQ_CALL: pc_q <= pc_i - 16'd1;
          SEQ_BRK:  pc_q <= pc_i + 16'd1;
          default:  pc_q <= pc_i;
        endcase
        if (load_kind_i == SEQ_RESET) begin
          st_q <= RST_STATUS;
          sp_q <= RST_SP;
        end else begin
          st_q <= status_i;
        end
      end else begin
        pc_q <= pc_cap;
        st_q <= st_cap;
        if (active_i) begin
          case (uop_i)
            UOP_PUSH_PCH, UOP_PUSH_PCL: sp_q <= sp_q - 8'd1;
            UOP_PUSH_ST: begin
              sp_q <= sp_q - 8'd1;
              if (kind_i == SEQ_IRQ || kind_i == SEQ_BRK) st_q <= st_q | I_MASK;
            end
            UOP_PULL_ST, UOP_PULL_PCL, UOP_PULL_PCH: sp_q <= sp_inc;
            UOP_END: begin
              if (kind_i == SEQ_CALL)     pc_q <= tgt_q;
              else if (kind_i == SEQ_RET) pc_q <= pc_cap + 16'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign pc_o     = pc_q;
  assign status_o = st_q;
  assign sp_o     = sp_q;

  // R2
  push_sp_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(sp_o) - 8'd1));
  // R2
  pull_sp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && (uop_i == UOP_PULL_PCL || uop_i == UOP_PULL_PCH || uop_i == UOP_PULL_ST))
      |=> (sp_o == $past(sp_o) + 8'd1));
  // R10
  rti_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && uop_i == UOP_PULL_ST) |=> ##1 ((status_o & BU_MASK) == BU_MASK));
endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
  import isq_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] RST_SP     = 8'hFD,
  parameter logic [DW-1:0] RST_STATUS = 8'h34,
  parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             nmi_i,
  input  logic             irq_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [DW-1:0]    status_i,
  input  logic [AW-1:0]    target_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_we_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [AW-1:0]    pc_o,
  output logic [DW-1:0]    status_o,
  output logic [DW-1:0]    sp_o,
  output logic             busy_o,
  output logic             done_o
);
  logic              active_q, done_q, cmd_ok;
  seq_e              kind_q, kind_d;
  logic [STEP_W-1:0] step_q;
  uop_e              uop;
  logic [N_REQ-1:0]  req_set, req_clr, pend;

  function automatic logic is_onehot(input logic [CMD_W-1:0] v);
    return (v != '0) && ((v & (v - CMD_W'(1))) == '0);
  endfunction

  assign cmd_ok = !active_q && is_onehot(cmd_i);

  always_comb begin
    kind_d = SEQ_NONE;
    if (cmd_i[CMD_RESET]) kind_d = SEQ_RESET;
    else if (cmd_i[CMD_POLL]) begin
      if (pend[REQ_NMI])                        kind_d = SEQ_NMI;
      else if (pend[REQ_IRQ] && !status_i[ST_I]) kind_d = SEQ_IRQ;
    end
    else if (cmd_i[CMD_BRK])  kind_d = SEQ_BRK;
    else if (cmd_i[CMD_CALL]) kind_d = SEQ_CALL;
    else if (cmd_i[CMD_RET])  kind_d = SEQ_RET;
    else if (cmd_i[CMD_RTI])  kind_d = SEQ_RTI;
  end

  assign req_set[REQ_NMI] = nmi_i;
  assign req_set[REQ_IRQ] = irq_i;
  assign req_clr[REQ_NMI] = cmd_ok && (kind_d == SEQ_NMI);
  assign req_clr[REQ_IRQ] = cmd_ok && (kind_d == SEQ_IRQ);

  isq_req_latch #(.N(N_REQ)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set),
    .clr_i  (req_clr),
    .pend_o (pend)
  );

  isq_uop_rom u_rom (
    .kind_i (kind_q),
    .step_i (step_q),
    .uop_o  (uop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= SEQ_NONE;
      step_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= active_q && (uop == UOP_END);
      if (cmd_ok) begin
        active_q <= 1'b1;
        kind_q   <= kind_d;
        step_q   <= '0;
      end else if (active_q) begin
        if (uop == UOP_END) active_q <= 1'b0;
        else                step_q   <= step_q + 1'b1;
      end
    end
  end

  isq_datapath #(
    .STACK_PAGE (STACK_PAGE),
    .RST_SP     (RST_SP),
    .RST_STATUS (RST_STATUS),
    .VEC_NMI    (VEC_NMI),
    .VEC_RST    (VEC_RST),
    .VEC_IRQ    (VEC_IRQ)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cmd_ok),
    .load_kind_i (kind_d),
    .active_i    (active_q),
    .kind_i      (kind_q),
    .uop_i       (uop),
    .pc_i        (pc_i),
    .status_i    (status_i),
    .target_i    (target_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .pc_o        (pc_o),
    .status_o    (status_o),
    .sp_o        (sp_o)
  );

  assign busy_o = active_q;
  assign done_o = done_q;

  // R3
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && cmd_i[CMD_POLL] && pend[REQ_NMI]) |=> (kind_q == SEQ_NMI));
  // R4
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && cmd_i[CMD_POLL] && !pend[REQ_NMI] && status_i[ST_I]) |=> (kind_q == SEQ_NONE));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  we_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(uop == UOP_END)) |=> busy_o);
endmodule

// File: tb/isq_sequencer_tb_top.sv
module isq_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cmd = '0;
  logic        nmi = 1'b0, irq = 1'b0;
  logic [15:0] pc_in = '0, tgt_in = '0;
  logic [7:0]  st_in = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] pc_o;
  logic [7:0]  status_o, sp_o;
  logic        busy_o, done_o;

  int checks = 0, errors = 0, bad_wr = 0, wn = 0;
  logic [7:0]  stk [256];
  logic [15:0] wa [8];
  logic [7:0]  wd [8];
  logic [7:0]  esp;
  int lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  isq_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .nmi_i(nmi), .irq_i(irq),
    .pc_i(pc_in), .status_i(st_in), .target_i(tgt_in),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .pc_o(pc_o), .status_o(status_o), .sp_o(sp_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // vectors: NMI A1B2, reset C3D4, IRQ E5F6
  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'hB2;
      16'hFFFB: return 8'hA1;
      16'hFFFC: return 8'hD4;
      16'hFFFD: return 8'hC3;
      16'hFFFE: return 8'hF6;
      16'hFFFF: return 8'hE5;
      default:  return a[7:0] ^ 8'h5A;
    endcase
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_addr[15:8] != 8'h01) bad_wr++;
      else stk[mem_addr[7:0]] <= mem_wdata;
      if (wn < 8) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
      wn++;
    end
    mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : rom_byte(mem_addr);
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] c, input logic [15:0] p, input logic [7:0] s,
                       input logic [15:0] t, input logic na, input logic ia,
                       input logic [5:0] bc, output int l);
    @(negedge clk);
    cmd = c; pc_in = p; st_in = s; tgt_in = t; nmi = na; irq = ia; wn = 0;
    @(negedge clk);
    cmd = bc; nmi = 1'b0; irq = 1'b0; l = 1;
    while (!done_o && l < 64) begin
      @(negedge clk);
      cmd = '0; l++;
    end
    cmd = '0;
  endtask

  task automatic pulse(input logic na, input logic ia);
    @(negedge clk); nmi = na; irq = ia;
    @(negedge clk); nmi = 1'b0; irq = 1'b0;
  endtask

  function automatic logic [15:0] call_pc(input int i);
    return 16'h1200 + 16'(i) * 16'h0103;
  endfunction

  // hardware entry / break frame check
  task automatic chk_frame(input string tag, input logic [15:0] p, input logic [7:0] s);
    chk(wn == 3, tag, wn, 3);
    chk(wa[0] == {8'h01, esp} && wd[0] == p[15:8], tag, {wa[0], wd[0]}, {8'h01, esp, p[15:8]});
    chk(wa[1] == {8'h01, esp - 8'd1} && wd[1] == p[7:0], tag, {wa[1], wd[1]}, {8'h01, esp - 8'd1, p[7:0]});
    chk(wa[2] == {8'h01, esp - 8'd2} && wd[2] == s, tag, {wa[2], wd[2]}, {8'h01, esp - 8'd2, s});
    esp = esp - 8'd3;
    chk(sp_o == esp, tag, sp_o, esp);
  endtask

  task automatic do_rti(input string tag, input logic [15:0] exp_pc, input logic [7:0] exp_st);
    issue(6'b100000, 16'h0, 8'h0, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    esp = esp + 8'd3;
    chk(lat == 5 && pc_o == exp_pc && status_o == exp_st && sp_o == esp && wn == 0,
        tag, {pc_o, status_o, sp_o}, {exp_pc, exp_st, esp});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp_o == 8'hFD && status_o == 8'h34, "R1 reset state", {sp_o, status_o}, 16'hFD34);
    chk(!busy_o && !done_o, "R11 idle after reset", {busy_o, done_o}, 0);

    // R1 reset command
    issue(6'b000001, 16'h1111, 8'hFF, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk(pc_o == 16'hC3D4, "R1 reset vector", pc_o, 16'hC3D4);
    chk(sp_o == 8'hFD && status_o == 8'h34, "R1 reset sp/status", {sp_o, status_o}, 16'hFD34);
    chk(lat == 4 && wn == 0, "R11 reset latency", lat, 4);
    esp = 8'hFD;

    // R8 / R2: 127 calls, SP wraps to FF
    for (int i = 0; i < 127; i++) begin
      logic [15:0] p, pm;
      p = call_pc(i); pm = p - 16'd1;
      issue(6'b001000, p, 8'h00, 16'h8000 + 16'(i), 1'b0, 1'b0, 6'b0, lat);
      chk(wn == 2 && wa[0] == {8'h01, esp} && wd[0] == pm[15:8] &&
          wa[1] == {8'h01, esp - 8'd1} && wd[1] == pm[7:0],
          "R8 call push", {wa[0], wd[0], wd[1]}, {8'h01, esp, pm});
      esp = esp - 8'd2;
      chk(pc_o == 16'h8000 + 16'(i) && sp_o == esp && lat == 4, "R8 call target",
          {pc_o, sp_o}, {16'h8000 + 16'(i), esp});
    end
    chk(sp_o == 8'hFF, "R2 stack wrap", sp_o, 8'hFF);

    // R9: unwind in LIFO order
    for (int i = 126; i >= 0; i--) begin
      issue(6'b010000, 16'hDEAD, 8'h00, 16'h0, 1'b0, 1'b0, 6'b0, lat);
      esp = esp + 8'd2;
      chk(pc_o == call_pc(i) && sp_o == esp && lat == 4 && wn == 0, "R9 return",
          {pc_o, sp_o}, {call_pc(i), esp});
    end
    chk(sp_o == 8'hFD && bad_wr == 0, "R2 page only", {sp_o, 8'(bad_wr)}, 16'hFD00);

    // R7 break
    issue(6'b000100, 16'h20FF, 8'h01, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk_frame("R7 break frame", 16'h2100, 8'h31);
    chk(pc_o == 16'hE5F6 && status_o == 8'h05 && lat == 7, "R7 break vector",
        {pc_o, status_o}, {16'hE5F6, 8'h05});

    // R10 forced bits on pull
    @(negedge clk); stk[8'hFB] = 8'h0A;
    do_rti("R10 return from interrupt", 16'h2100, 8'h3A);

    // R4 masked IRQ
    pulse(1'b0, 1'b1);
    issue(6'b000010, 16'h3456, 8'h04, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk(wn == 0 && lat == 2 && pc_o == 16'h3456 && status_o == 8'h04 && sp_o == esp,
        "R4 masked irq", {pc_o, status_o, sp_o}, {16'h3456, 8'h04, esp});
    // R5 / R6 now unmasked, still pending
    issue(6'b000010, 16'h3456, 8'h30, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk_frame("R5 irq frame", 16'h3456, 8'h20);
    chk(pc_o == 16'hE5F6 && status_o == 8'h34 && lat == 7, "R5 irq vector",
        {pc_o, status_o}, {16'hE5F6, 8'h34});
    issue(6'b000010, 16'h7777, 8'h30, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk(wn == 0 && lat == 2 && pc_o == 16'h7777, "R6 irq latch cleared", pc_o, 16'h7777);
    do_rti("R10 irq return", 16'h3456, 8'h30);

    // R3 NMI with interrupt disable set
    pulse(1'b1, 1'b0);
    issue(6'b000010, 16'h2345, 8'h14, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk_frame("R3 nmi frame", 16'h2345, 8'h04);
    chk(pc_o == 16'hA1B2 && status_o == 8'h14 && lat == 7, "R3 nmi vector",
        {pc_o, status_o}, {16'hA1B2, 8'h14});
    do_rti("R10 nmi return", 16'h2345, 8'h34);

    // R6 / R3: NMI re-arrives in the cycle its latch clears, IRQ waits behind
    pulse(1'b1, 1'b1);
    issue(6'b000010, 16'h4000, 8'h00, 16'h0, 1'b1, 1'b0, 6'b0, lat);
    chk_frame("R3 nmi over irq", 16'h4000, 8'h00);
    chk(pc_o == 16'hA1B2, "R3 nmi over irq vector", pc_o, 16'hA1B2);
    issue(6'b000010, 16'h5000, 8'h00, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk_frame("R6 nmi set during clear", 16'h5000, 8'h00);
    chk(pc_o == 16'hA1B2, "R6 second nmi vector", pc_o, 16'hA1B2);
    issue(6'b000010, 16'h6000, 8'h00, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk_frame("R6 irq after nmis", 16'h6000, 8'h00);
    chk(pc_o == 16'hE5F6 && status_o == 8'h04, "R6 irq vector", {pc_o, status_o}, {16'hE5F6, 8'h04});
    issue(6'b000010, 16'h6100, 8'h00, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk(wn == 0 && lat == 2, "R6 all serviced", wn, 0);
    do_rti("R10 unwind 1", 16'h6000, 8'h30);
    do_rti("R10 unwind 2", 16'h5000, 8'h30);
    do_rti("R10 unwind 3", 16'h4000, 8'h30);

    // R6 request during a running sequence; R12 command while busy ignored
    issue(6'b001000, 16'h9000, 8'h00, 16'hABCD, 1'b0, 1'b1, 6'b000001, lat);
    esp = esp - 8'd2;
    chk(pc_o == 16'hABCD && sp_o == esp && lat == 4, "R12 busy command ignored",
        {pc_o, sp_o}, {16'hABCD, esp});
    @(negedge clk);
    chk(!busy_o && !done_o, "R11 done one cycle", {busy_o, done_o}, 0);
    issue(6'b000010, 16'h9100, 8'h00, 16'h0, 1'b0, 1'b0, 6'b0, lat);
    chk_frame("R6 irq held across call", 16'h9100, 8'h00);
    chk(pc_o == 16'hE5F6, "R6 held irq vector", pc_o, 16'hE5F6);

    // R12 multi-hot ignored
    @(negedge clk); cmd = 6'b001010; wn = 0;
    @(negedge clk); cmd = '0;
    chk(!busy_o, "R12 multi-hot busy", busy_o, 0);
    repeat (4) @(negedge clk);
    chk(wn == 0 && !done_o && sp_o == esp && pc_o == 16'hE5F6, "R12 multi-hot no effect",
        {pc_o, sp_o}, {16'hE5F6, esp});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule